// File: doc/BRIEF.md
# Floating-Point Exception Status Controller

This block sits beside an embedded floating-point datapath and turns the exception flags that each completed operation reports into three decisions. It decides whether a data interrupt must be raised, whether a round interrupt must be raised, and whether the destination register may be written. It also keeps a software-visible control and status word. That word holds five enable bits and five sticky status bits.

An operation is presented as a one-cycle `op_valid` pulse together with five flags: invalid/input error, divide by zero, underflow, overflow and inexact. Each flag is handled in one of two ways. If its enable is set, it raises an interrupt and the register writeback is suppressed. If its enable is clear, the datapath supplies a default result, and this block lets the writeback through. An underflow or overflow that falls back to a default result is also counted as inexact.

Sticky bits collect every flag seen since software last cleared them. Only a software write can clear a sticky bit. The arithmetic and the interrupt vectoring live elsewhere.

Top module: `fpx_status_ctrl`

## Requirements
- R1: After reset, `csr_rdata` is zero and `data_irq`, `round_irq` and `wb_en` are all 0.
- R2: Register layout: bit 0 enables invalid, bit 1 divide-by-zero, bit 2 underflow, bit 3 overflow and bit 4 inexact. Bits 8 to 12 are the sticky bits for the same five conditions in the same order. All other bits read as zero and ignore writes.
- R3: Each sticky bit becomes the OR of its current value and the matching effective flag of every valid operation. The result is visible on `csr_rdata` in the cycle after the operation.
- R4: Hardware never clears a sticky bit. A sticky bit falls only when `sw_wr_en` writes it with 0.
- R5: When a software write and a valid operation fall in the same cycle, the new sticky field is the written value ORed with the operation's effective flags. The enable field takes the written value.
- R6: A valid operation whose invalid, divide-by-zero, underflow or overflow flag is set raises `data_irq`, provided the matching enable is set. `data_irq` is a one-cycle pulse in the cycle after the operation.
- R7: A valid operation whose effective inexact flag is set raises `round_irq` in the cycle after the operation, provided the inexact enable is set.
- R8: `wb_en` pulses in the cycle after a valid operation only if neither interrupt is raised for it. It is never high together with either interrupt.
- R9: An underflow or overflow whose own enable is clear also sets the effective inexact flag. This affects both the inexact sticky bit and `round_irq`.
- R10: An operation is judged against the enable bits held before any software write in the same cycle.
- R11: Flags presented while `op_valid` is 0 have no effect on the outputs or on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | One floating-point operation completes this cycle |
| op_invalid | input | 1 | Invalid operation or input error flag |
| op_divzero | input | 1 | Divide by zero flag |
| op_underflow | input | 1 | Underflow flag |
| op_overflow | input | 1 | Overflow flag |
| op_inexact | input | 1 | Inexact (round) flag |
| sw_wr_en | input | 1 | Software write strobe for the control/status word |
| sw_wr_data | input | W | Software write data |
| csr_rdata | output | W | Current control/status word |
| data_irq | output | 1 | Data interrupt request pulse |
| round_irq | output | 1 | Round interrupt request pulse |
| wb_en | output | 1 | Destination register write enable pulse |

## Verification
A software write to the status word and a completing operation can land on the same clock edge. One collision occurs when the write clears the sticky bits while the operation raises new flags. Another occurs when the write changes the enables that the operation is judged against. Directed steps set up both cases with fixed expected words. A long random phase then makes writes and operations coincide often, and a behavioural model checks every cycle. In that model, the sticky field becomes the written value ORed with the flags, and interrupts follow the enables held before the write.

// File: rtl/fpx_status_ctrl.sv
module fpx_status_ctrl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic         op_invalid,
  input  logic         op_divzero,
  input  logic         op_underflow,
  input  logic         op_overflow,
  input  logic         op_inexact,
  input  logic         sw_wr_en,
  input  logic [W-1:0] sw_wr_data,
  output logic [W-1:0] csr_rdata,
  output logic         data_irq,
  output logic         round_irq,
  output logic         wb_en
);
  localparam int NF = 5;
  localparam int STK_LO = 8;
  localparam int STK_HI = STK_LO + NF - 1;

  logic [NF-1:0] en_q, stk_q;
  logic          dirq_q, rirq_q, wb_q;

  wire implied_inx = (op_underflow & ~en_q[2]) | (op_overflow & ~en_q[3]);
  wire [NF-1:0] eff = op_valid ?
    {op_inexact | implied_inx, op_overflow, op_underflow, op_divzero, op_invalid} : '0;
  wire take_data  = |(eff[3:0] & en_q[3:0]);
  wire take_round = eff[4] & en_q[4];

  wire unused_wr = ^{sw_wr_data[W-1:STK_HI+1], sw_wr_data[STK_LO-1:NF]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stk_q  <= '0;
      dirq_q <= 1'b0;
      rirq_q <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      dirq_q <= take_data;
      rirq_q <= take_round;
      wb_q   <= op_valid & ~take_data & ~take_round;
      if (sw_wr_en) en_q <= sw_wr_data[NF-1:0];
      stk_q  <= (sw_wr_en ? sw_wr_data[STK_HI:STK_LO] : stk_q) | eff;
    end
  end

  always_comb begin
    csr_rdata = '0;
    csr_rdata[NF-1:0] = en_q;
    csr_rdata[STK_HI:STK_LO] = stk_q;
  end

  assign data_irq  = dirq_q;
  assign round_irq = rirq_q;
  assign wb_en     = wb_q;
endmodule

// File: rtl/fpx_status_ctrl_chk.sv
module fpx_status_ctrl_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_underflow,
  input logic         sw_wr_en,
  input logic [12:0]  wdata_lo,
  input logic [W-1:0] csr_rdata,
  input logic         data_irq,
  input logic         round_irq,
  input logic         wb_en
);
  logic started;
  wire unused_lo = ^wdata_lo[7:5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[W-1:13] == '0 && csr_rdata[7:5] == '0);

  a_r8_wb_excl: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (!data_irq && !round_irq));

  a_r6_irq_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
    (started && (data_irq || round_irq || wb_en)) |-> $past(op_valid));

  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(sw_wr_en)) |->
      ((csr_rdata[12:8] & $past(csr_rdata[12:8])) == $past(csr_rdata[12:8])));

  a_r5_write_or: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(sw_wr_en)) |->
      (csr_rdata[4:0] == $past(wdata_lo[4:0]) &&
       (csr_rdata[12:8] & $past(wdata_lo[12:8])) == $past(wdata_lo[12:8])));

  a_r9_implied_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(op_valid && op_underflow && !csr_rdata[2])) |-> csr_rdata[12]);
endmodule

bind fpx_status_ctrl fpx_status_ctrl_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_underflow(op_underflow),
  .sw_wr_en(sw_wr_en), .wdata_lo(sw_wr_data[12:0]), .csr_rdata(csr_rdata),
  .data_irq(data_irq), .round_irq(round_irq), .wb_en(wb_en)
);

// File: tb/test_fpx_status_ctrl.sv
module test_fpx_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 0, op_invalid = 0, op_divzero = 0, op_underflow = 0, op_overflow = 0, op_inexact = 0;
  logic sw_wr_en = 0;
  logic [W-1:0] sw_wr_data = '0;
  logic [W-1:0] csr_rdata;
  logic data_irq, round_irq, wb_en;

  int checks = 0, failures = 0;
  int m_en = 0, m_st = 0;
  bit m_dirq = 0, m_rirq = 0, m_wb = 0;
  bit done = 0;

  fpx_status_ctrl #(.W(W)) i_fpx_status_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    expect_eq("R3 csr word", csr_rdata, (m_st << 8) | m_en);
    expect_eq("R6 data_irq", data_irq, m_dirq);
    expect_eq("R7 round_irq", round_irq, m_rirq);
    expect_eq("R8 wb_en", wb_en, m_wb);
  endtask

  // flag vector bit order: 0 invalid, 1 divzero, 2 underflow, 3 overflow, 4 inexact
  task automatic step(input bit v, input bit [4:0] f, input bit w, input logic [W-1:0] d);
    int eff;
    @(negedge clk);
    op_valid = v; op_invalid = f[0]; op_divzero = f[1];
    op_underflow = f[2]; op_overflow = f[3]; op_inexact = f[4];
    sw_wr_en = w; sw_wr_data = d;
    eff = v ? int'(f) : 0;
    if (v && f[2] && (m_en & 4) == 0) eff |= 16;
    if (v && f[3] && (m_en & 8) == 0) eff |= 16;
    m_dirq = (eff & m_en & 15) != 0;
    m_rirq = (eff & m_en & 16) != 0;
    m_wb   = v && !m_dirq && !m_rirq;
    if (w) begin
      m_en = int'(d) & 31;
      m_st = (int'(d) >> 8) & 31;
    end
    m_st |= eff;
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_eq("R1 reset csr", csr_rdata, 0);
    expect_eq("R1 reset irqs/wb", {data_irq, round_irq, wb_en}, 0);
    rst_n = 1'b1;

    step(0, 5'h00, 1, 32'hFFFF_FFFF);
    expect_eq("R2 layout", csr_rdata, 32'h0000_1F1F);
    step(0, 5'h00, 1, 32'h0000_0000);
    expect_eq("R4 software clear", csr_rdata, 0);

    step(1, 5'h02, 0, '0);
    expect_eq("R3 divzero sticky", csr_rdata, 32'h0000_0200);
    expect_eq("R8 default writeback", wb_en, 1);
    step(0, 5'h1F, 0, '0);
    expect_eq("R11 flags without valid", csr_rdata, 32'h0000_0200);
    expect_eq("R11 no pulse", {data_irq, round_irq, wb_en}, 0);
    step(0, 5'h00, 0, '0);
    expect_eq("R4 sticky held", csr_rdata, 32'h0000_0200);

    step(1, 5'h04, 0, '0);
    expect_eq("R9 underflow implies inexact", csr_rdata, 32'h0000_1600);
    step(0, 5'h00, 1, 32'h0000_0010);
    step(1, 5'h08, 0, '0);
    expect_eq("R9 overflow default round_irq", round_irq, 1);
    expect_eq("R8 suppressed by round", wb_en, 0);

    step(0, 5'h00, 1, 32'h0000_0008);
    step(1, 5'h08, 0, '0);
    expect_eq("R6 enabled overflow", data_irq, 1);
    expect_eq("R8 suppressed by data", wb_en, 0);
    expect_eq("R6 no implied inexact", round_irq, 0);
    step(0, 5'h00, 0, '0);
    expect_eq("R6 single pulse", data_irq, 0);

    step(1, 5'h01, 1, 32'h0000_0000);
    expect_eq("R5 write OR flags", csr_rdata, 32'h0000_0100);
    step(1, 5'h01, 1, 32'h0000_0001);
    expect_eq("R10 old enables used", data_irq, 0);
    expect_eq("R10 csr", csr_rdata, 32'h0000_0101);
    step(1, 5'h01, 0, '0);
    expect_eq("R10 new enable active", data_irq, 1);

    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 2) == 0;
      bit w = ($urandom % 8) == 0;
      step(v, 5'($urandom), w, $urandom);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule